// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Engine

This block is the bus-side controller of an 8192-byte serial EEPROM that answers as a two-wire (I2C) slave. The SCL and SDA lines reach it unsynchronised. It brings them into the system clock domain and finds START, repeated START and STOP events. It checks the device select byte against a fixed device code and three chip-enable inputs, takes in a two-byte memory address, and then either accepts write bytes or sends read bytes. It pulls SDA low through an output-enable signal, which is active high and means "drive low".

The engine keeps a 13-bit address counter. On the array side it asks for a byte with a one-cycle read request, and the byte comes back on the following cycle. Each write byte it accepts is handed to a write-commit controller through a staging pulse. A STOP that arrives in the right slot tells that controller to program the array. While the controller reports busy, the engine stays off the bus. This lets a master poll the device until it answers again.

Top module: `eep_slave_engine`

## Requirements
- R1: After reset, sda_oe is 0, mem_addr is 0, and no mem_rd, wr_stage or commit_req pulse occurs until the bus is used.
- R2: A select byte whose upper seven bits equal binary 1010 followed by chip_en[2], chip_en[1], chip_en[0] is acknowledged. Bit 0 is the direction: 1 means read, 0 means write. Any other select byte gets no acknowledge, and the engine ignores the bus until the next START.
- R3: After a write select, two address bytes are acknowledged. Bits 4:0 of the first byte become address bits 12:8, and its bits 7:5 are ignored. The second byte becomes address bits 7:0.
- R4: Each accepted write byte gives one wr_stage pulse, with mem_addr holding the byte's address. After the byte, only address bits 4:0 increment, so writes past the end of a 32-byte row wrap to the start of the same row.
- R5: While wp is 1, select and address bytes are still acknowledged. Data bytes are not acknowledged, produce no wr_stage pulse and produce no commit_req.
- R6: A read sends the byte at the address counter, MSB first, and then increments the counter. When the master acknowledges, the next byte follows. The counter wraps from 0x1FFF to 0x0000.
- R7: If the master does not acknowledge a read byte, the engine releases SDA and drives nothing until the next START.
- R8: commit_req pulses only for a STOP that comes directly after the acknowledge of an accepted write byte, with at most one SCL rise in between. A STOP anywhere else, or a write with no accepted data byte, does not pulse commit_req.
- R9: While wc_busy is 1, the engine does not acknowledge anything, including a matching select byte.
- R10: A START or STOP that arrives in the middle of a byte returns the engine to idle and leaves the address counter unchanged.
- R11: sda_oe changes only after SCL has gone low, or because of a START, a STOP or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| chip_en | input | 3 | Chip-enable levels compared against select bits 3:1 |
| wp | input | 1 | Write protect; 1 blocks data bytes |
| mem_addr | output | 13 | Address counter: array read and staging address |
| mem_rd | output | 1 | One-cycle read request at mem_addr |
| mem_rdata | input | 8 | Array byte, valid the cycle after mem_rd |
| wr_stage | output | 1 | One-cycle pulse: stage wr_data at mem_addr |
| wr_data | output | 8 | Byte being staged |
| commit_req | output | 1 | One-cycle pulse: program the staged bytes |
| wc_busy | input | 1 | Write-commit cycle in progress |

## Verification
Write traffic is tried in four forms: one byte, a four-byte burst that crosses a row end, the same with wp held high, and bursts cut short by a STOP placed outside the slot or by a partial byte. Together these separate row wrap from full-array wrap and show which acknowledges write protect removes. Reads are tried as random, sequential across the top of the array, and current-address after both a normal end and an aborted frame. These cases separate counter loading, counter increment and counter preservation. Select bytes with a wrong device code, wrong chip-enable bits and a correct code sent while busy show that only the correct code, with the engine idle, gets an acknowledge.

// File: rtl/eep_pkg.sv
// Shared types and constants of the serial EEPROM slave engine.
package eep_pkg;
    // Fixed device-type code in select byte bits 7:4.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Byte-level phase of the bus engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } eep_state_t;
endpackage

// File: rtl/eep_line_sampler.sv
// Line sampler: two-flop synchroniser on SCL and SDA plus one history flop
// on each. Produces single-cycle SCL edge strobes and START/STOP strobes.
// Assumes SCL and SDA hold each level for several clk cycles.
module eep_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_p;

    // Synchronise both lines. The idle level of the bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
        end else begin
            scl_m <= scl_in; scl_s <= scl_m; scl_p <= scl_s;
            sda_m <= sda_in; sda_s <= sda_m; sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_addr_ctr.sv
// Address counter. Loads a full address, or increments either inside the
// current row (low PAGE_W bits only) or across the whole array.
module eep_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_row,
    input  logic              inc_all,
    output logic [ADDR_W-1:0] addr
);
    // Counter update; load has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc_row)
            addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
        else if (inc_all)
            addr <= addr + 1'b1;
    end

    // R4: a row increment never leaves the row.
    p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_row && !load) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

    // R6: an array increment from the top address wraps to zero.
    p_array_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_all && !load && !inc_row && addr == '1) |=> addr == '0);
endmodule

// File: rtl/eep_slave_engine.sv
// Serial EEPROM bus slave engine. Decodes the select byte and the two
// address bytes, stages write bytes, streams read bytes and answers with
// an acknowledge. Drives SDA only through sda_oe (1 = pull low).
// Assumes: mem_rdata is valid the cycle after mem_rd; wc_busy is held
// high by the commit controller for the whole programming time.
module eep_slave_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5,
    parameter int CE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [CE_W-1:0]   chip_en,
    input  logic              wp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              wr_stage,
    output logic [7:0]        wr_data,
    output logic              commit_req,
    input  logic              wc_busy
);
    localparam int HI_W = ADDR_W - 8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    eep_state_t state;
    logic [3:0]      cnt;
    logic [7:0]      rx, tx;
    logic [HI_W-1:0] hi;
    logic acked, is_read, staged, rd_wait;
    logic ld_q, incr_q, inca_q;

    eep_line_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_q), .load_val({hi, rx}),
        .inc_row(incr_q), .inc_all(inca_q), .addr(mem_addr)
    );

    // Byte and bit sequencing, acknowledge and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; rx <= '0; tx <= '0; hi <= '0;
            sda_oe <= 1'b0; acked <= 1'b0; is_read <= 1'b0; staged <= 1'b0;
            rd_wait <= 1'b0; mem_rd <= 1'b0; wr_stage <= 1'b0; wr_data <= '0;
            commit_req <= 1'b0; ld_q <= 1'b0; incr_q <= 1'b0; inca_q <= 1'b0;
        end else begin
            mem_rd <= 1'b0; wr_stage <= 1'b0; commit_req <= 1'b0;
            ld_q <= 1'b0; incr_q <= 1'b0; inca_q <= 1'b0;
            rd_wait <= mem_rd;
            if (rd_wait) tx <= mem_rdata;
            if (wc_busy) begin
                state <= ST_IDLE; sda_oe <= 1'b0; staged <= 1'b0;
            end else if (start_det) begin
                state <= ST_DEV; cnt <= '0; sda_oe <= 1'b0; staged <= 1'b0;
            end else if (stop_det) begin
                if (state == ST_WDAT && staged && cnt <= 4'd1) commit_req <= 1'b1;
                state <= ST_IDLE; sda_oe <= 1'b0; staged <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: ;
                    ST_RDAT: begin
                        if (scl_rise && cnt < 4'd8) cnt <= cnt + 4'd1;
                        else if (scl_rise && cnt == 4'd8) begin
                            if (!sda_s) begin cnt <= 4'd9; mem_rd <= 1'b1; end
                            else state <= ST_IDLE;
                        end
                        if (scl_fall) begin
                            if (cnt >= 4'd1 && cnt <= 4'd7) begin
                                sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
                            end else if (cnt == 4'd8) begin
                                sda_oe <= 1'b0; inca_q <= 1'b1;
                            end else if (cnt == 4'd9) begin
                                sda_oe <= ~tx[7]; cnt <= '0;
                            end
                        end
                    end
                    default: begin
                        if (scl_rise && cnt < 4'd8) begin
                            rx <= {rx[6:0], sda_s}; cnt <= cnt + 4'd1;
                        end
                        if (scl_fall && cnt == 4'd8) begin
                            cnt <= 4'd9;
                            case (state)
                                ST_DEV: begin
                                    if (rx[7:1] == {DEV_CODE, chip_en}) begin
                                        sda_oe <= 1'b1; is_read <= rx[0];
                                        if (rx[0]) mem_rd <= 1'b1;
                                    end else state <= ST_IDLE;
                                end
                                ST_AHI: begin hi <= rx[HI_W-1:0]; sda_oe <= 1'b1; end
                                ST_ALO: begin ld_q <= 1'b1; sda_oe <= 1'b1; end
                                default: begin
                                    acked <= !wp;
                                    if (!wp) begin
                                        sda_oe <= 1'b1; wr_stage <= 1'b1;
                                        wr_data <= rx; staged <= 1'b1;
                                    end
                                end
                            endcase
                        end
                        if (scl_fall && cnt == 4'd9) begin
                            sda_oe <= 1'b0; cnt <= '0;
                            case (state)
                                ST_DEV: begin
                                    if (is_read) begin state <= ST_RDAT; sda_oe <= ~tx[7]; end
                                    else state <= ST_AHI;
                                end
                                ST_AHI: state <= ST_ALO;
                                ST_ALO: state <= ST_WDAT;
                                default: if (acked) incr_q <= 1'b1;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // R9: busy forces the line released on the next cycle.
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wc_busy |=> !sda_oe);

    // R8: a commit request always follows a detected STOP.
    p_commit_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> $past(stop_det));

    // R5: no byte is staged while write protect is high.
    p_stage_unprotected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stage |-> $past(!wp));

    // R11: the drive changes only after SCL falls or on a bus event or busy.
    p_oe_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det || wc_busy));
endmodule

// File: tb/eep_slave_engine_bench.sv
module eep_slave_engine_bench;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] chip_en = 3'b101;
    logic wp = 1'b0;
    logic sda_oe, mem_rd, wr_stage, commit_req;
    logic [12:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00, wr_data;
    logic wc_busy;
    wire sda_line = sda_m & ~sda_oe;

    int errors = 0, checks = 0;
    int n_stage = 0, n_commit = 0, busy_cnt = 0, bad_edges = 0, oe_seen = 0;
    logic [12:0] stg_a [0:255];
    logic [7:0]  stg_d [0:255];
    logic [7:0]  wmem [int];
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    eep_slave_engine u_eep_slave_engine (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .chip_en(chip_en), .wp(wp), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .wr_stage(wr_stage),
        .wr_data(wr_data), .commit_req(commit_req), .wc_busy(wc_busy)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    function automatic logic [7:0] model(input logic [12:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return pat(a);
    endfunction

    assign wc_busy = busy_cnt > 0;

    // Array, staging and commit controller model.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= model(mem_addr);
        if (wr_stage) begin
            stg_a[n_stage] <= mem_addr; stg_d[n_stage] <= wr_data;
            n_stage <= n_stage + 1;
        end
        if (commit_req) begin
            for (int i = 0; i < n_stage; i++) wmem[int'(stg_a[i])] = stg_d[i];
            n_commit <= n_commit + 1;
            busy_cnt <= 400;
        end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (sda_oe !== prev_oe && scl_m) bad_edges <= bad_edges + 1;
        if (sda_oe) oe_seen <= oe_seen + 1;
        prev_oe <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(T); scl_m = 1'b1; wt(T); sda_m = 1'b0; wt(T); scl_m = 1'b0; wt(T);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(T); scl_m = 1'b1; wt(T); sda_m = 1'b1; wt(T);
    endtask

    task automatic put_bits(input int n, input logic [7:0] b);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(T); scl_m = 1'b1; wt(T); scl_m = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        put_bits(8, b);
        sda_m = 1'b1; wt(T); scl_m = 1'b1; wt(T/2); ack = !sda_line; wt(T/2); scl_m = 1'b0;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(T); scl_m = 1'b1; wt(T/2); b[i] = sda_line; wt(T/2); scl_m = 1'b0;
        end
        sda_m = !mack; wt(T); scl_m = 1'b1; wt(T); scl_m = 1'b0; wt(2); sda_m = 1'b1;
    endtask

    task automatic wait_idle;
        wt(4);
        while (wc_busy) wt(1);
    endtask

    // Write select, address bytes; returns the three acks packed.
    task automatic set_addr(input logic [7:0] hb, input logic [7:0] lb, output bit [2:0] acks);
        bit a;
        bus_start;
        put_byte({4'hA, chip_en, 1'b0}, a); acks[2] = a;
        put_byte(hb, a); acks[1] = a;
        put_byte(lb, a); acks[0] = a;
    endtask

    task automatic rand_read(input logic [12:0] addr, output logic [7:0] b);
        bit [2:0] acks; bit a;
        set_addr({3'b000, addr[12:8]}, addr[7:0], acks);
        bus_start; put_byte({4'hA, chip_en, 1'b1}, a);
        get_byte(1'b0, b); bus_stop;
    endtask

    task automatic t_reset;
        check(sda_oe == 1'b0, "R1 oe", int'(sda_oe), 0);
        check(mem_addr == 13'h0, "R1 addr", int'(mem_addr), 0);
        check(n_stage == 0 && n_commit == 0, "R1 pulses", n_stage + n_commit, 0);
    endtask

    task automatic t_devsel;
        bit a;
        bus_start; put_byte({4'hA, 3'b011, 1'b0}, a);
        check(!a, "R2 wrong chip-enable", int'(a), 0);
        put_byte({4'hA, chip_en, 1'b0}, a);
        check(!a, "R2 idle after mismatch", int'(a), 0);
        bus_stop;
        bus_start; put_byte({4'hB, chip_en, 1'b0}, a);
        check(!a, "R2 wrong device code", int'(a), 0);
        bus_stop;
        bus_start; put_byte({4'hA, chip_en, 1'b0}, a);
        check(a, "R2 match", int'(a), 1);
        bus_stop; wt(8);
    endtask

    task automatic t_byte_write;
        bit [2:0] acks; bit a; int s0, c0;
        s0 = n_stage; c0 = n_commit;
        set_addr(8'hE0, 8'hA5, acks);
        check(acks == 3'b111, "R3 select/address ack", int'(acks), 7);
        put_byte(8'h3C, a);
        check(a, "R4 data ack", int'(a), 1);
        bus_stop; wt(4);
        check(n_stage == s0 + 1 && stg_a[s0] == 13'h0A5 && stg_d[s0] == 8'h3C,
              "R4 staged byte", int'(stg_a[s0]), 'h0A5);
        check(n_commit == c0 + 1, "R8 commit in slot", n_commit - c0, 1);
    endtask

    task automatic t_poll;
        bit a; logic [7:0] b;
        bus_start; put_byte({4'hA, chip_en, 1'b0}, a);
        check(!a, "R9 busy nack", int'(a), 0);
        bus_stop;
        wait_idle;
        bus_start; put_byte({4'hA, chip_en, 1'b0}, a);
        check(a, "R9 ack after busy", int'(a), 1);
        bus_stop;
        rand_read(13'h0A5, b);
        check(b == 8'h3C, "R3 random read back", int'(b), 'h3C);
    endtask

    task automatic t_row_wrap;
        bit [2:0] acks; bit a; int s0; logic [7:0] b;
        s0 = n_stage;
        set_addr(8'h01, 8'h3E, acks);
        put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a); put_byte(8'h44, a);
        bus_stop; wait_idle;
        check(stg_a[s0] == 13'h13E && stg_a[s0+1] == 13'h13F, "R4 row start", int'(stg_a[s0+1]), 'h13F);
        check(stg_a[s0+2] == 13'h120 && stg_a[s0+3] == 13'h121, "R4 row wrap", int'(stg_a[s0+2]), 'h120);
        rand_read(13'h120, b);
        check(b == 8'h33, "R4 wrapped data", int'(b), 'h33);
    endtask

    task automatic t_protect;
        bit [2:0] acks; bit a; int s0, c0; logic [7:0] b;
        s0 = n_stage; c0 = n_commit; wp = 1'b1;
        set_addr(8'h00, 8'h40, acks);
        check(acks == 3'b111, "R5 address ack under wp", int'(acks), 7);
        put_byte(8'h99, a);
        check(!a, "R5 data nack", int'(a), 0);
        bus_stop; wt(8);
        check(n_stage == s0 && n_commit == c0, "R5 nothing staged", n_stage - s0, 0);
        wp = 1'b0;
        rand_read(13'h040, b);
        check(b == pat(13'h040), "R5 data kept", int'(b), int'(pat(13'h040)));
    endtask

    task automatic t_seq_wrap;
        bit [2:0] acks; bit a; logic [7:0] b0, b1, b2, b3; int seen0;
        set_addr(8'h1F, 8'hFE, acks);
        bus_start; put_byte({4'hA, chip_en, 1'b1}, a);
        get_byte(1'b1, b0); get_byte(1'b1, b1); get_byte(1'b0, b2);
        check(b0 == pat(13'h1FFE) && b1 == pat(13'h1FFF), "R6 sequential", int'(b1), int'(pat(13'h1FFF)));
        check(b2 == pat(13'h0000), "R6 array wrap", int'(b2), int'(pat(13'h0000)));
        seen0 = oe_seen;
        put_byte(8'h00, a); put_byte(8'h00, a);
        check(oe_seen == seen0, "R7 silent after master nack", oe_seen - seen0, 0);
        bus_stop;
        bus_start; put_byte({4'hA, chip_en, 1'b1}, a); get_byte(1'b0, b3); bus_stop;
        check(b3 == pat(13'h0001), "R6 current address", int'(b3), int'(pat(13'h0001)));
    endtask

    task automatic t_stop_slot;
        bit [2:0] acks; bit a; int c0; logic [7:0] b;
        c0 = n_commit;
        set_addr(8'h00, 8'h50, acks); put_byte(8'h77, a);
        put_bits(3, 8'hFF); bus_stop; wt(8);
        check(n_commit == c0, "R8 late stop", n_commit - c0, 0);
        set_addr(8'h00, 8'h51, acks); bus_stop; wt(8);
        check(n_commit == c0, "R8 no data", n_commit - c0, 0);
        rand_read(13'h050, b);
        check(b == pat(13'h050), "R8 array unchanged", int'(b), int'(pat(13'h050)));
    endtask

    task automatic t_abort;
        bit a; logic [7:0] b;
        rand_read(13'h100, b);
        check(b == pat(13'h100), "R10 setup read", int'(b), int'(pat(13'h100)));
        bus_start; put_byte({4'hA, chip_en, 1'b0}, a); put_byte(8'h02, a);
        put_bits(4, 8'hA0);
        bus_start; put_byte({4'hA, chip_en, 1'b1}, a); get_byte(1'b0, b); bus_stop;
        check(b == pat(13'h101), "R10 start mid-byte", int'(b), int'(pat(13'h101)));
        bus_start; put_byte({4'hA, chip_en, 1'b0}, a); put_byte(8'h03, a);
        put_bits(2, 8'h00); bus_stop;
        bus_start; put_byte({4'hA, chip_en, 1'b1}, a); get_byte(1'b0, b); bus_stop;
        check(b == pat(13'h102), "R10 stop mid-byte", int'(b), int'(pat(13'h102)));
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(5);
        t_reset;
        t_devsel;
        t_byte_write;
        t_poll;
        t_row_wrap;
        t_protect;
        t_seq_wrap;
        t_stop_slot;
        t_abort;
        check(bad_edges == 0, "R11 drive timing", bad_edges, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule